// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a synchronous on-chip requester read and write an external asynchronous byte-wide static RAM. The requester gives one access at a time on a valid/ready handshake: an address, a write byte and a write flag. The controller registers the request, drives the memory's address bus and its three active-low strobes (chip select, output enable and write strobe), and controls the byte-wide data bus. That bus is split into an outgoing value, an incoming value and a driver enable. A read returns its byte with a one-cycle response pulse.

Each access is built from whole clock cycles. A parameter gives the clock period in nanoseconds, and the memory's timing limits are also given in nanoseconds. The controller turns each limit into a cycle count by dividing and rounding up, with at least one cycle. A write that follows a read first holds the bus quiet, with output enable released and the controller's drivers off, until the memory's outputs are guaranteed to float. Every access ends with one recovery cycle with the chip deselected. Only then is a new request accepted.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted, and whenever no access is in progress, mem_ce_n, mem_oe_n and mem_we_n are all 1, mem_dq_oe is 0, req_ready is 1 and rsp_valid is 0. Asserting the asynchronous reset during an access returns the outputs to this state at once.
- R2: During every read-access cycle, mem_ce_n=0, mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0, and mem_addr equals the accepted request address.
- R3: During every write-pulse cycle, mem_ce_n=0, mem_we_n=0, mem_oe_n=1 and mem_dq_oe=1, and mem_dq_out equals the accepted write byte. The byte is stored at the accepted address.
- R4: A read access lasts ceil(max(tRC, tAA, tACE, tOE) / CLK_NS) cycles, with a minimum of 1. The read byte is sampled on the clock edge that ends the last of these cycles.
- R5: Each read produces exactly one rsp_valid pulse, one cycle long, in the cycle after the access ends, with rsp_rdata equal to the sampled byte. A write produces no pulse.
- R6: A write pulse lasts max(ceil(max(tWP, tAW, tDW) / CLK_NS), ceil(tWC / CLK_NS) - 1) cycles, with a minimum of 1.
- R7: If the most recent access since reset was a read, a write is preceded by ceil(tOHZ / CLK_NS) turnaround cycles (minimum 1) with mem_ce_n=0, mem_oe_n=1, mem_we_n=1 and mem_dq_oe=0. The first write after reset, and a write after a write, start the pulse immediately.
- R8: Every access ends with exactly one recovery cycle in which mem_ce_n=1. req_ready is 1 only when idle. A request presented while req_ready is 0 is ignored.
- R9: mem_addr and mem_dq_out hold the registered request for the whole access, whatever happens on the request inputs after acceptance.
- R10: mem_dq_oe is never 1 while mem_oe_n is 0, and the write strobe never falls in the cycle right after output enable was asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | DATA_W | Byte read |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq_out | output | DATA_W | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | DATA_W | Value seen on the data bus |

## Verification
The assertions assume that reset is asserted from time zero and that the memory model presents read data on mem_dq_in only while the controller holds a read encoding. They also assume no other agent drives the data bus. The bench's model follows this: it answers only when chip select and output enable are low with the write strobe high, and otherwise returns a fixed filler byte. The bench keeps req_valid asserted with a junk request throughout every busy period. It also changes the request fields right after acceptance, so that hold and ignore rules are tested against hostile inputs that still stay within the handshake.

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int T_RC_NS  = 10,
  parameter int T_AA_NS  = 10,
  parameter int T_ACE_NS = 8,
  parameter int T_OE_NS  = 5,
  parameter int T_WP_NS  = 8,
  parameter int T_AW_NS  = 8,
  parameter int T_DW_NS  = 6,
  parameter int T_WC_NS  = 10,
  parameter int T_OHZ_NS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  function automatic int to_cyc(int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC   = to_cyc(max2(max2(T_RC_NS, T_AA_NS), max2(T_ACE_NS, T_OE_NS)));
  localparam int WR_CYC   = max2(to_cyc(max2(T_WP_NS, max2(T_AW_NS, T_DW_NS))), to_cyc(T_WC_NS) - 1);
  localparam int TURN_CYC = to_cyc(T_OHZ_NS);
  localparam int MAX_CYC  = max2(RD_CYC, max2(WR_CYC, TURN_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_TURN, S_WR, S_REC} state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              after_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      after_rd  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          if (!req_write) begin
            state <= S_RD;
            cnt   <= CNT_W'(RD_CYC - 1);
          end else if (after_rd) begin
            state <= S_TURN;
            cnt   <= CNT_W'(TURN_CYC - 1);
          end else begin
            state <= S_WR;
            cnt   <= CNT_W'(WR_CYC - 1);
          end
        end
        S_RD: if (cnt == '0) begin
          rsp_rdata <= mem_dq_in;
          rsp_valid <= 1'b1;
          after_rd  <= 1'b1;
          state     <= S_REC;
        end else cnt <= cnt - 1'b1;
        S_TURN: if (cnt == '0) begin
          state <= S_WR;
          cnt   <= CNT_W'(WR_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_WR: if (cnt == '0) begin
          after_rd <= 1'b0;
          state    <= S_REC;
        end else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == S_IDLE);
  assign mem_ce_n   = !(state == S_RD || state == S_TURN || state == S_WR);
  assign mem_oe_n   = (state != S_RD);
  assign mem_we_n   = (state != S_WR);
  assign mem_dq_oe  = (state == S_WR);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);

  a_r1_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_oe_n && mem_we_n && !mem_dq_oe));

  a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  a_r10_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mem_oe_n) |-> mem_we_n);

  a_r5_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n);

  a_r8_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!mem_ce_n) && mem_ce_n) |-> !req_ready);

  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_sram_ctrl.sv
module test_sram_ctrl;
  localparam int AW = 19;
  localparam int DW = 8;
  // Expected counts from the requirements with the overrides below, 10 ns clock:
  // R4: max(10,25,8,5)=25 -> 3; R6: max(18,8,6)=18 -> 2, 10/10-1=0 -> 2; R7: 15 -> 2
  localparam int RD_EXP   = 3;
  localparam int WR_EXP   = 2;
  localparam int TURN_EXP = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out, mem_dq_in;

  int total = 0;
  int bad = 0;
  bit prev_rd = 1'b0;
  logic [DW-1:0] model [256];

  always #5 clk = ~clk;

  sram_ctrl #(.T_AA_NS(25), .T_WP_NS(18), .T_OHZ_NS(15)) i_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? model[mem_addr[7:0]] : 8'hEE;

  always @(posedge clk)
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) model[mem_addr[7:0]] <= mem_dq_out;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic chk_idle(input string req);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready && !rsp_valid, req,
        {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready, rsp_valid}, 6'b111010);
  endtask

  task automatic op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic [DW-1:0] e);
    int n_rd = 0, n_wr = 0, n_turn = 0, n_rec = 0, n_other = 0, n_addr = 0;
    int n_rsp = 0, n_wait = 0;
    logic [DW-1:0] got = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1;
    // keep a junk request pending while busy (R8, R9)
    req_write = ~w; req_addr = ~a; req_wdata = ~d;
    forever begin
      @(negedge clk);
      if (req_ready) begin
        req_valid = 1'b0;
        break;
      end
      n_wait++;
      if (n_wait > 50) break;
      if (!mem_ce_n && mem_addr != a) n_addr++;
      if (rsp_valid) begin n_rsp++; got = rsp_rdata; end
      if (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_dq_oe) n_rd++;
      else if (!mem_ce_n && mem_oe_n && !mem_we_n && mem_dq_oe && mem_dq_out == d) n_wr++;
      else if (!mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe) n_turn++;
      else if (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe) n_rec++;
      else n_other++;
    end
    chk(n_addr == 0, "R9 address held", n_addr, 0);
    chk(n_rec == 1, "R8 recovery cycles", n_rec, 1);
    chk(n_other == 0, "R10 illegal strobe mix", n_other, 0);
    if (w) begin
      chk(n_wr == WR_EXP, "R6 write pulse length", n_wr, WR_EXP);
      chk(n_turn == (prev_rd ? TURN_EXP : 0), "R7 turnaround cycles", n_turn,
          prev_rd ? TURN_EXP : 0);
      chk(n_rsp == 0, "R5 no response on write", n_rsp, 0);
      chk(n_rd == 0, "R3 write encoding", n_rd, 0);
      prev_rd = 1'b0;
    end else begin
      chk(n_rd == RD_EXP, "R4 read length", n_rd, RD_EXP);
      chk(n_wr == 0 && n_turn == 0, "R2 read encoding", n_wr + n_turn, 0);
      chk(n_rsp == 1, "R5 response pulse count", n_rsp, 1);
      chk(got == e, "R2 R3 read data", got, e);
      prev_rd = 1'b1;
    end
  endtask

  // {write, addr, wdata, expected read}
  localparam logic [35:0] VEC [9] = '{
    {1'b1, 19'h00012, 8'hA5, 8'h00},
    {1'b1, 19'h7FFFF, 8'h3C, 8'h00},
    {1'b0, 19'h00012, 8'h00, 8'hA5},
    {1'b1, 19'h00000, 8'h5A, 8'h00},
    {1'b0, 19'h7FFFF, 8'h00, 8'h3C},
    {1'b0, 19'h00000, 8'h00, 8'h5A},
    {1'b1, 19'h00012, 8'hFF, 8'h00},
    {1'b1, 19'h00034, 8'h00, 8'h00},
    {1'b0, 19'h00012, 8'h00, 8'hFF}
  };

  initial begin
    #2_000_000;
    chk(1'b0, "R8 watchdog", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk_idle("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 idle after reset");

    for (int i = 0; i < 9; i++)
      op(VEC[i][35], VEC[i][34:16], VEC[i][15:8], VEC[i][7:0]);

    repeat (2) @(negedge clk);
    chk_idle("R1 idle between accesses");

    // R1: asynchronous reset in the middle of a read
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 19'h00034;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    chk(!mem_ce_n && !mem_oe_n, "R2 read started", {mem_ce_n, mem_oe_n}, 0);
    rst_n = 1'b0;
    #1;
    chk_idle("R1 reset aborts access");
    @(negedge clk);
    rst_n = 1'b1;
    prev_rd = 1'b0;
    // R7: first write after reset starts the pulse at once
    op(1'b1, 19'h00034, 8'h77, 8'h00);
    op(1'b0, 19'h00034, 8'h00, 8'h77);
    op(1'b1, 19'h00034, 8'h81, 8'h00);
    op(1'b0, 19'h00034, 8'h00, 8'h81);
    finish_run();
  end
endmodule